// File: doc/BRIEF.md
# Flash Write Status Generator

This block stands in for the status side of a byte-wide parallel NOR flash. It holds a small array and runs timed internal program and erase operations. While an operation runs, the read port returns a status byte instead of array data. A command strobe starts an operation. It carries the operation kind, the address, the data, a mask of the sectors to erase, and a live map of protected sectors. Each operation is modelled as a busy counter whose length in clock cycles is set by a parameter. Everything runs on one clock.

In the status byte, the top bit is the polling bit and the bit below it is the toggle bit. All lower bits read 0. The polling bit shows the inverse of the top data bit during a program and 0 during an erase. The toggle bit flips on every read. A program aimed at a protected sector runs a short status-only window and leaves the array unchanged. An erase whose selected sectors are all protected does the same with a longer window. An erase request can be held off with a suspend input. An active-low busy output marks the running algorithm.

Top module: `flash_wstat`

## Requirements
- R1: After reset is released, `busy_n` is 1 and `rd_data` is 0. With no operation running, a read returns the stored array byte on the cycle after `rd_en`.
- R2: A program accepted on an unprotected sector holds `busy_n` low for exactly PROG_CYC clock edges after the accepting edge. Reads during that window return the top bit equal to the inverse of the top bit of the programmed data.
- R3: A finished program stores the bitwise AND of the old byte and the programmed byte. Bits can only go from 1 to 0.
- R4: During an erase, status reads return a top bit of 0. The erase lasts ERASE_CYC edges. Afterwards every byte of the selected, unprotected sectors reads all ones, and every other byte keeps its value.
- R5: While an operation is active (busy low), each read at any address returns the status byte: top bit the polling bit, next bit the toggle bit, all lower bits 0. The toggle bit is 0 on the first read after a command is accepted and flips on every later read.
- R6: A program whose sector (the top SECT_W address bits) has its `prot_map` bit set gives a status window of PPROT_CYC edges with `busy_n` low. The array is left unchanged.
- R7: An erase in which every selected sector is protected, or no sector is selected, gives a status window of EPROT_CYC edges with a top bit of 0. The array is left unchanged.
- R8: When `susp_req` is high during an erase, the block enters suspend on the next edge. In suspend, `busy_n` is 1, reads return a top bit of 1 and a toggle bit that does not flip, and the remaining erase time is frozen. When `susp_req` drops, the erase resumes for the edges still owed.
- R9: Reset aborts a running program at once. The target byte keeps its old value and `busy_n` returns to 1.
- R10: A `cmd_go` that arrives while an operation is active or suspended is ignored.
- R11: The first read sampled on the edge after the final edge of an operation returns the stored array byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_go | input | 1 | Final write strobe of a command, one cycle |
| cmd_erase | input | 1 | 1 = erase, 0 = program |
| cmd_addr | input | ADDR_W | Program target address |
| cmd_data | input | DATA_W | Program data |
| erase_sel | input | 2**SECT_W | Sectors selected for erase |
| prot_map | input | 2**SECT_W | Per-sector protect flags, sampled at command acceptance |
| susp_req | input | 1 | Erase suspend request, level |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Array byte or status byte, registered |
| busy_n | output | 1 | Low while an algorithm runs |

## Verification
`rd_data` is due on the edge after the one that samples `rd_en`. `busy_n` falls right after the accepting edge and rises right after the last counted edge. The bench drives and samples one time unit after each rising edge. It keeps a count of the edges still owed by the running operation: busy is expected high only once that count reaches zero. The array model is updated on that same edge, so the read that follows is checked against the new contents. Suspend and resume edges are stepped without reads, and the count of owed edges stays unchanged across them.

// File: rtl/flash_wstat_pkg.sv
package flash_wstat_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PROG,
      ST_ERASE,
      ST_FAKE,
      ST_SUSP
   } fws_state_e;
endpackage

// File: rtl/flash_wstat_timer.sv
module flash_wstat_timer #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             run,
   output logic [CNT_W-1:0] cnt,
   output logic             expired
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (run && (cnt != '0))
         cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/flash_wstat_array.sv
module flash_wstat_array #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8,
   parameter int SECT_W = 2
) (
   input  logic                 clk,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic                 er_en,
   input  logic [(1<<SECT_W)-1:0] er_mask,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [DATA_W-1:0]    rd_q
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(w);
      localparam int SECT = w >> (ADDR_W - SECT_W);
      always_ff @(posedge clk) begin
         if (er_en && er_mask[SECT])
            mem[w] <= '1;
         else if (wr_en && (wr_addr == WADDR))
            mem[w] <= mem[w] & wr_data;
      end
   end

   assign rd_q = mem[rd_addr];
endmodule

// File: rtl/flash_wstat_rdmux.sv
module flash_wstat_rdmux #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              clr_tog,
   input  logic              active,
   input  logic              suspended,
   input  logic              poll,
   input  logic [DATA_W-1:0] arr_q,
   output logic [DATA_W-1:0] rd_data,
   output logic              tog_q
);
   localparam int LOW_W = DATA_W - 2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         tog_q   <= 1'b0;
      end else begin
         if (clr_tog)
            tog_q <= 1'b0;
         else if (rd_en && active)
            tog_q <= ~tog_q;

         if (rd_en) begin
            if (active)
               rd_data <= {poll, tog_q, {LOW_W{1'b0}}};
            else if (suspended)
               rd_data <= {1'b1, tog_q, {LOW_W{1'b0}}};
            else
               rd_data <= arr_q;
         end
      end
   end
endmodule

// File: rtl/flash_wstat.sv
module flash_wstat
   import flash_wstat_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int DATA_W     = 8,
   parameter int SECT_W     = 2,
   parameter int PROG_CYC   = 12,
   parameter int ERASE_CYC  = 40,
   parameter int PPROT_CYC  = 5,
   parameter int EPROT_CYC  = 20
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cmd_go,
   input  logic                    cmd_erase,
   input  logic [ADDR_W-1:0]       cmd_addr,
   input  logic [DATA_W-1:0]       cmd_data,
   input  logic [(1<<SECT_W)-1:0]  erase_sel,
   input  logic [(1<<SECT_W)-1:0]  prot_map,
   input  logic                    susp_req,
   input  logic                    rd_en,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [DATA_W-1:0]       rd_data,
   output logic                    busy_n
);
   localparam int NSECT = 1 << SECT_W;
   localparam int MAX_A = (PROG_CYC > PPROT_CYC) ? PROG_CYC : PPROT_CYC;
   localparam int MAX_B = (ERASE_CYC > EPROT_CYC) ? ERASE_CYC : EPROT_CYC;
   localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CNT_W = $clog2(MAXC + 1);

   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must hold the polling and toggle bits");
   end
   if (SECT_W < 1 || SECT_W > ADDR_W) begin : g_bad_sect
      $error("SECT_W must lie in 1..ADDR_W");
   end
   if (PROG_CYC < 1 || ERASE_CYC < 1 || PPROT_CYC < 1 || EPROT_CYC < 1) begin : g_bad_len
      $error("every window length must be at least one cycle");
   end

   fws_state_e          st;
   logic [ADDR_W-1:0]   op_addr;
   logic [DATA_W-1:0]   op_data;
   logic                op_erase;
   logic [NSECT-1:0]    er_mask;
   logic [NSECT-1:0]    cmd_mask;
   logic                cmd_prot;
   logic [CNT_W-1:0]    cnt, load_val;
   logic                expired, run, accept;
   logic                wr_en, er_en, active, poll, tog_q;
   logic [DATA_W-1:0]   arr_q;

   assign accept   = (st == ST_IDLE) && cmd_go;
   assign cmd_mask = erase_sel & ~prot_map;
   assign cmd_prot = prot_map[cmd_addr[ADDR_W-1 -: SECT_W]];

   always_comb begin
      if (cmd_erase)
         load_val = (cmd_mask != '0) ? CNT_W'(ERASE_CYC - 1) : CNT_W'(EPROT_CYC - 1);
      else
         load_val = cmd_prot ? CNT_W'(PPROT_CYC - 1) : CNT_W'(PROG_CYC - 1);
   end

   assign run = (st == ST_PROG) || (st == ST_FAKE) || ((st == ST_ERASE) && !susp_req);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         op_addr  <= '0;
         op_data  <= '0;
         op_erase <= 1'b0;
         er_mask  <= '0;
      end else begin
         unique case (st)
            ST_IDLE: if (cmd_go) begin
               op_addr  <= cmd_addr;
               op_data  <= cmd_data;
               op_erase <= cmd_erase;
               er_mask  <= cmd_mask;
               if (cmd_erase)
                  st <= (cmd_mask != '0) ? ST_ERASE : ST_FAKE;
               else
                  st <= cmd_prot ? ST_FAKE : ST_PROG;
            end
            ST_PROG, ST_FAKE: if (expired) st <= ST_IDLE;
            ST_ERASE: begin
               if (susp_req)     st <= ST_SUSP;
               else if (expired) st <= ST_IDLE;
            end
            ST_SUSP: if (!susp_req) st <= ST_ERASE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign wr_en  = (st == ST_PROG) && expired;
   assign er_en  = (st == ST_ERASE) && !susp_req && expired;
   assign active = (st == ST_PROG) || (st == ST_ERASE) || (st == ST_FAKE);
   assign poll   = op_erase ? 1'b0 : ~op_data[DATA_W-1];
   assign busy_n = ~active;

   flash_wstat_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_val(load_val),
      .run(run), .cnt(cnt), .expired(expired)
   );

   flash_wstat_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_array (
      .clk(clk), .wr_en(wr_en), .wr_addr(op_addr), .wr_data(op_data),
      .er_en(er_en), .er_mask(er_mask), .rd_addr(rd_addr), .rd_q(arr_q)
   );

   flash_wstat_rdmux #(.DATA_W(DATA_W)) u_rdmux (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .clr_tog(accept),
      .active(active), .suspended(st == ST_SUSP), .poll(poll),
      .arr_q(arr_q), .rd_data(rd_data), .tog_q(tog_q)
   );

   // R10
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE && cmd_go) |=> ($stable(op_addr) && $stable(op_data) && $stable(op_erase)));

   // R5
   tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && rd_en) |=> (tog_q != $past(tog_q)));

   // R8
   susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SUSP) |=> $stable(cnt));

   // R2
   prog_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PROG && expired) |=> (st == ST_IDLE && busy_n));

   // R4
   erase_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ERASE) |-> (er_mask != '0));
endmodule

// File: tb/flash_wstat_tb.sv
module flash_wstat_tb;
   localparam int CLK_PER = 10;
   localparam int AW = 6, DW = 8, SW = 2, NS = 4, DEPTH = 64;
   localparam int L_PROG = 12, L_ERASE = 40, L_PPROT = 5, L_EPROT = 20;

   logic clk = 0, rst_n = 0;
   logic cmd_go = 0, cmd_erase = 0, susp_req = 0, rd_en = 0;
   logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
   logic [DW-1:0] cmd_data = '0, rd_data;
   logic [NS-1:0] erase_sel = '0, prot_map = '0;
   logic busy_n;

   always #(CLK_PER/2) clk = ~clk;

   flash_wstat u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_erase(cmd_erase),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .erase_sel(erase_sel),
      .prot_map(prot_map), .susp_req(susp_req), .rd_en(rd_en),
      .rd_addr(rd_addr), .rd_data(rd_data), .busy_n(busy_n)
   );

   int total = 0, bad = 0;
   logic [DW-1:0] exp_mem [DEPTH];
   int remain;
   logic tog, poll;
   int pend_kind;
   logic [AW-1:0] pend_addr;
   logic [DW-1:0] pend_data;
   logic [NS-1:0] pend_mask;
   bit done = 0;

   function automatic logic [DW-1:0] stat_byte(logic p, logic t);
      return {p, t, 6'b0};
   endfunction

   task automatic chk8(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk1(string req, logic act, logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic do_read(logic [AW-1:0] a);
      rd_en = 1; rd_addr = a;
      tick();
      rd_en = 0;
   endtask

   task automatic apply_pending();
      if (pend_kind == 1)
         exp_mem[pend_addr] = exp_mem[pend_addr] & pend_data;
      else if (pend_kind == 2)
         for (int i = 0; i < DEPTH; i++)
            if (pend_mask[i >> 4]) exp_mem[i] = '1;
      pend_kind = 0;
   endtask

   task automatic start_op(logic er, logic [AW-1:0] a, logic [DW-1:0] d, logic [NS-1:0] sel);
      logic [NS-1:0] m;
      cmd_go = 1; cmd_erase = er; cmd_addr = a; cmd_data = d; erase_sel = sel;
      tick();
      cmd_go = 0;
      tog = 0; pend_addr = a; pend_data = d;
      m = sel & ~prot_map;
      pend_mask = m;
      if (!er) begin
         poll = ~d[7];
         if (prot_map[a[5:4]]) begin remain = L_PPROT; pend_kind = 0; end
         else begin remain = L_PROG; pend_kind = 1; end
      end else begin
         poll = 1'b0;
         if (m != '0) begin remain = L_ERASE; pend_kind = 2; end
         else begin remain = L_EPROT; pend_kind = 0; end
      end
      // R2 R6 R7: busy drops right after the accepting edge
      chk1("R2 busy after accept", busy_n, 1'b0);
   endtask

   // reads through n active edges; optional stray command on the first (R10)
   task automatic active_reads(int n, bit stray);
      for (int i = 0; i < n; i++) begin
         if (stray && i == 0) begin
            cmd_go = 1; cmd_erase = 0; cmd_addr = pend_addr ^ 6'd1; cmd_data = 8'h00;
         end
         do_read(6'($urandom_range(0, DEPTH-1)));
         cmd_go = 0;
         // R5 status byte with toggle bit
         chk8("R5 status byte", rd_data, stat_byte(poll, tog));
         tog = ~tog;
         remain--;
         if (remain == 0) apply_pending();
         chk1("R2 busy window", busy_n, remain == 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] a, other;
      logic [DW-1:0] d, old;
      logic [NS-1:0] s;
      process::self().srandom(32'd1234);
      pend_kind = 0;
      for (int i = 0; i < DEPTH; i++) exp_mem[i] = '1;
      repeat (3) tick();
      rst_n = 1;
      tick();
      // R1 reset state
      chk1("R1 busy after reset", busy_n, 1'b1);
      chk8("R1 rd_data after reset", rd_data, 8'h00);

      // full erase to a known array, no protection
      start_op(1'b1, '0, '0, 4'b1111);
      active_reads(remain, 0);
      do_read(6'd17);
      // R11 first read after finish, R4 erased byte
      chk8("R11 R4 erased byte", rd_data, 8'hFF);

      prot_map = 4'b1000;

      // R3 AND semantics: program 0xA5 then 0x3C on same byte
      start_op(1'b0, 6'd5, 8'hA5, '0);
      active_reads(remain, 1);   // stray command on first edge (R10)
      do_read(6'd5);
      chk8("R3 first program", rd_data, exp_mem[5]);
      do_read(6'd4);
      chk8("R10 stray target unchanged", rd_data, exp_mem[4]);
      start_op(1'b0, 6'd5, 8'h3C, '0);
      active_reads(remain, 0);
      do_read(6'd5);
      chk8("R3 AND of old and new", rd_data, 8'h24);

      // R6 program to protected sector 3
      start_op(1'b0, 6'd50, 8'h12, '0);
      active_reads(remain, 0);
      do_read(6'd50);
      chk8("R6 protected byte unchanged", rd_data, 8'hFF);

      // R7 erase of only protected sector
      start_op(1'b1, '0, '0, 4'b1000);
      active_reads(remain, 0);
      do_read(6'd5);
      chk8("R7 array untouched", rd_data, 8'h24);

      // R4 partial erase: sector 0 erased, sector 3 protected
      start_op(1'b0, 6'd52, 8'h00, '0);  // protected, no change
      active_reads(remain, 0);
      start_op(1'b0, 6'd20, 8'h0F, '0);
      active_reads(remain, 0);
      start_op(1'b1, '0, '0, 4'b1001);
      active_reads(remain, 0);
      do_read(6'd5);
      chk8("R4 sector0 erased", rd_data, 8'hFF);
      do_read(6'd20);
      chk8("R4 sector1 kept", rd_data, 8'h0F);

      // R8 suspend in the middle of an erase of sector 1
      start_op(1'b1, '0, '0, 4'b0010);
      active_reads(3, 0);
      susp_req = 1;
      tick();
      chk1("R8 ready while suspended", busy_n, 1'b1);
      for (int k = 0; k < 4; k++) begin
         do_read(6'($urandom_range(0, DEPTH-1)));
         chk8("R8 suspend status", rd_data, stat_byte(1'b1, tog));
         chk1("R8 busy_n stays high", busy_n, 1'b1);
      end
      cmd_go = 1; cmd_erase = 0; cmd_addr = 6'd2; cmd_data = 8'h00;
      tick();
      cmd_go = 0;
      susp_req = 0;
      tick();
      chk1("R8 busy after resume", busy_n, 1'b0);
      active_reads(remain, 0);
      do_read(6'd20);
      chk8("R8 erase completed", rd_data, 8'hFF);
      do_read(6'd2);
      chk8("R10 command in suspend ignored", rd_data, 8'hFF);

      // R9 reset aborts a program
      start_op(1'b0, 6'd9, 8'h00, '0);
      pend_kind = 0;
      active_reads(3, 0);
      rst_n = 0;
      tick();
      rst_n = 1;
      tick();
      chk1("R9 busy after abort", busy_n, 1'b1);
      chk8("R9 rd_data cleared", rd_data, 8'h00);
      do_read(6'd9);
      chk8("R9 byte kept", rd_data, exp_mem[9]);

      // random mix
      for (int n = 0; n < 30; n++) begin
         if ($urandom_range(0, 3) != 0) begin
            a = 6'($urandom_range(0, DEPTH-1));
            d = 8'($urandom);
            start_op(1'b0, a, d, '0);
            active_reads(remain, 0);
            do_read(a);
            chk8("R11 R3 random program", rd_data, exp_mem[a]);
         end else begin
            s = 4'($urandom);
            start_op(1'b1, '0, '0, s);
            active_reads(remain, 0);
            other = 6'($urandom_range(0, DEPTH-1));
            do_read(other);
            chk8("R11 R4 random erase", rd_data, exp_mem[other]);
         end
         old = exp_mem[0];
         do_read(6'd0);
         chk8("R1 idle array read", rd_data, old);
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule